// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block takes one cached 64-bit segment descriptor, an access kind (read, write or execute) and a 32-bit offset. From these it returns either the linear address of the access or a fault code. It unpacks the base and limit fields, which are split across several bytes of the descriptor. It widens the limit when page granularity is selected. It then checks the offset against the limit, for both upward-growing and downward-growing data segments, and checks that the descriptor kind permits the requested access.

It sits between a descriptor cache and the address path of a memory pipeline. Each request is accepted through a valid/ready pair, and the result is held in a single output register with its own valid/ready pair. The block does not fetch descriptors, index tables or compare privilege. The privilege field is carried in but not used.

Top module: `seg_xlate_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Descriptor byte k is `req_desc[8k+7:8k]`. The base is byte 7 followed by bytes 4, 3 and 2, from most to least significant. The 20-bit limit is byte 6 bits 3:0 followed by bytes 1 and 0. A permitted access returns fault 0 and `rsp_lin` = base + offset, modulo 2^32. The privilege bits (byte 5 bits 6:5), byte 6 bit 4 and byte 6 bit 5 have no effect.
- R3: Byte 6 bit 7 selects granularity. When it is 0, the effective limit is the raw limit. When it is 1, the effective limit is raw limit × 4096 + 4095.
- R4: For any segment other than an expand-down data segment, an offset greater than the effective limit gives fault 1 (general protection). An offset equal to the effective limit is permitted.
- R5: A data segment with type bit 2 set grows downward. Its permitted offsets are those strictly above the effective limit and no greater than an upper bound. The upper bound is 0xFFFF when byte 6 bit 6 is 0 and 0xFFFFFFFF when that bit is 1. Other offsets give fault 1.
- R6: When the present flag (byte 5 bit 7) is 0, the result is fault 2 (not present), whatever the type, access or offset.
- R7: Byte 5 bit 4 = 1 with type bit 3 = 1 marks a code segment. Execute is permitted. A write gives fault 1. A read gives fault 1 unless type bit 1 (readable) is set.
- R8: Byte 5 bit 4 = 1 with type bit 3 = 0 marks a data segment. A read is permitted. A write gives fault 1 unless type bit 1 (writable) is set. An execute gives fault 1. Any access through a descriptor with byte 5 bit 4 = 0 gives fault 1. Access code 3 gives fault 1. Access codes are 0 read, 1 write and 2 execute.
- R9: Fault codes are ranked. Fault 2 outranks every check of type and limit. A request that breaks both a type rule and a limit rule gives fault 1.
- R10: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and its result appears with `rsp_valid` = 1 from the next cycle. While `rsp_valid` is 1 and `rsp_ready` is 0, the output stays unchanged and `req_ready` is 0.
- R11: Whenever the fault code is not 0, `rsp_lin` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_desc | input | 64 | Cached segment descriptor, byte 0 in the low bits |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_off | input | 32 | Offset within the segment |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_lin | output | 32 | Linear address, or 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 general protection, 2 not present |

## Verification
Base or limit bits taken from the wrong byte show up as a wrong `rsp_lin` or a wrong fault code. This appears in the cycle after the first descriptor whose bytes differ in those places. A limit boundary shifted by one, or an expand-down check applied the wrong way round, only shows when an offset lands on or next to the effective limit or the upper bound. The directed cases therefore place offsets on both sides of each edge. A wrong output-register hold shows within one stalled cycle, either as a changed result or as `req_ready` staying high while the output is stalled.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_EXEC  = 2'd2,
      ACC_RSVD  = 2'd3
   } acc_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_GP   = 2'd1,
      FLT_NP   = 2'd2
   } flt_e;

   typedef struct packed {
      logic [31:0] base;
      logic [19:0] limit;
      logic [3:0]  kind;
      logic        sys_n;
      logic [1:0]  priv;
      logic        present;
      logic        spare;
      logic        wide;
      logic        gran;
   } desc_t;
endpackage

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
   import seg_xlate_pkg::*;
(
   input  logic [63:0] raw,
   output desc_t       fld
);
   localparam int BYTES = 8;
   logic [7:0] b [BYTES];

   for (genvar k = 0; k < BYTES; k++) begin : g_byte
      assign b[k] = raw[8*k +: 8];
   end

   always_comb begin
      fld.base    = {b[7], b[4], b[3], b[2]};
      fld.limit   = {b[6][3:0], b[1], b[0]};
      fld.kind    = b[5][3:0];
      fld.sys_n   = b[5][4];
      fld.priv    = b[5][6:5];
      fld.present = b[5][7];
      fld.spare   = b[6][4];
      fld.wide    = b[6][6];
      fld.gran    = b[6][7];
   end

   logic unused_rsv;
   assign unused_rsv = b[6][5];
endmodule

// File: rtl/seg_limit_eval.sv
module seg_limit_eval #(
   parameter int ADDR_W     = 32,
   parameter int LIM_W      = 20,
   parameter int PAGE_SHIFT = 12,
   parameter bit EXP_DN_EN  = 1'b1
) (
   input  logic [LIM_W-1:0]  limit,
   input  logic              gran,
   input  logic              wide,
   input  logic              grow_dn,
   input  logic [ADDR_W-1:0] off,
   output logic              in_bounds
);
   localparam int NARROW_W = 16;

   if (LIM_W + PAGE_SHIFT != ADDR_W) begin : g_bad_w
      $error("limit width plus page shift must equal address width");
   end
   if (ADDR_W < NARROW_W) begin : g_bad_a
      $error("address width below narrow bound");
   end

   logic [ADDR_W-1:0] eff_lim;
   logic [ADDR_W-1:0] top;

   assign eff_lim = gran ? {limit, {PAGE_SHIFT{1'b1}}}
                         : {{(ADDR_W-LIM_W){1'b0}}, limit};
   assign top     = wide ? {ADDR_W{1'b1}}
                         : {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

   if (EXP_DN_EN) begin : g_dn
      always_comb begin
         if (grow_dn) in_bounds = (off > eff_lim) && (off <= top);
         else         in_bounds = (off <= eff_lim);
      end
   end else begin : g_up
      assign in_bounds = (off <= eff_lim);
      logic unused_dn;
      assign unused_dn = grow_dn ^ (|top);
   end
endmodule

// File: rtl/seg_access_rules.sv
module seg_access_rules
   import seg_xlate_pkg::*;
(
   input  logic       sys_n,
   input  logic [3:0] kind,
   input  acc_e       acc,
   output logic       type_ok,
   output logic       grow_dn
);
   logic is_code;
   assign is_code = kind[3];
   assign grow_dn = sys_n && !is_code && kind[2];

   always_comb begin
      type_ok = 1'b0;
      if (sys_n) begin
         if (is_code) begin
            unique case (acc)
               ACC_EXEC:  type_ok = 1'b1;
               ACC_READ:  type_ok = kind[1];
               default:   type_ok = 1'b0;
            endcase
         end else begin
            unique case (acc)
               ACC_READ:  type_ok = 1'b1;
               ACC_WRITE: type_ok = kind[1];
               default:   type_ok = 1'b0;
            endcase
         end
      end
   end
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LIM_W      = 20,
   parameter int PAGE_SHIFT = 12,
   parameter bit EXP_DN_EN  = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [63:0] req_desc,
   input  logic [1:0]  req_acc,
   input  logic [31:0] req_off,
   output logic        rsp_valid,
   input  logic        rsp_ready,
   output logic [31:0] rsp_lin,
   output logic [1:0]  rsp_fault
);
   if (ADDR_W != 32 || LIM_W != 20) begin : g_bad_fmt
      $error("descriptor layout fixes a 32-bit base and 20-bit limit");
   end

   desc_t fld;
   logic  type_ok, grow_dn, in_bounds;
   flt_e  flt_c;
   logic [ADDR_W-1:0] lin_c;

   seg_desc_unpack u_unpack (
      .raw (req_desc),
      .fld (fld)
   );

   seg_access_rules u_rules (
      .sys_n   (fld.sys_n),
      .kind    (fld.kind),
      .acc     (acc_e'(req_acc)),
      .type_ok (type_ok),
      .grow_dn (grow_dn)
   );

   seg_limit_eval #(
      .ADDR_W     (ADDR_W),
      .LIM_W      (LIM_W),
      .PAGE_SHIFT (PAGE_SHIFT),
      .EXP_DN_EN  (EXP_DN_EN)
   ) u_limit (
      .limit     (fld.limit),
      .gran      (fld.gran),
      .wide      (fld.wide),
      .grow_dn   (grow_dn),
      .off       (req_off),
      .in_bounds (in_bounds)
   );

   always_comb begin
      if (!fld.present)   flt_c = FLT_NP;
      else if (!type_ok)  flt_c = FLT_GP;
      else if (!in_bounds) flt_c = FLT_GP;
      else                flt_c = FLT_NONE;
      lin_c = (flt_c == FLT_NONE) ? fld.base + req_off : '0;
   end

   assign req_ready = !rsp_valid || rsp_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_lin   <= '0;
         rsp_fault <= FLT_NONE;
      end else if (req_ready) begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_lin   <= lin_c;
            rsp_fault <= flt_c;
         end
      end
   end

   logic unused_fld;
   assign unused_fld = ^{fld.priv, fld.spare};
endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_ready,
   input logic [63:0] req_desc,
   input logic [1:0]  req_acc,
   input logic        rsp_valid,
   input logic        rsp_ready,
   input logic [31:0] rsp_lin,
   input logic [1:0]  rsp_fault
);
   a_r10_take_shows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid);

   a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_lin) && $stable(rsp_fault));

   a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |-> !req_ready);

   a_r6_absent_np: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_desc[47] |=> rsp_fault == 2'd2);

   a_r8_system_gp: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_desc[47] && !req_desc[44] |=> rsp_fault == 2'd1);

   a_r8_rsvd_acc_gp: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_desc[47] && req_acc == 2'd3 |=> rsp_fault == 2'd1);

   a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault != 2'd0 |-> rsp_lin == 32'd0);
endmodule

bind seg_xlate_unit seg_xlate_sva u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_desc  (req_desc),
   .req_acc   (req_acc),
   .rsp_valid (rsp_valid),
   .rsp_ready (rsp_ready),
   .rsp_lin   (rsp_lin),
   .rsp_fault (rsp_fault)
);

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_desc = '0;
   logic [1:0]  req_acc = '0;
   logic [31:0] req_off = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b1;
   logic [31:0] rsp_lin;
   logic [1:0]  rsp_fault;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [33:0] exp_q [$];
   string       tag_q [$];

   always #4 clk = ~clk;

   seg_xlate_unit u0 (
      .clk, .rst_n, .req_valid, .req_ready, .req_desc, .req_acc, .req_off,
      .rsp_valid, .rsp_ready, .rsp_lin, .rsp_fault
   );

   function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                      input logic [3:0] typ, input bit s, input bit p,
                                      input bit db, input bit g, input logic [1:0] dpl,
                                      input bit avl);
      logic [63:0] d = '0;
      d[15:0]  = lim[15:0];
      d[39:16] = base[23:0];
      d[43:40] = typ;
      d[44]    = s;
      d[46:45] = dpl;
      d[47]    = p;
      d[51:48] = lim[19:16];
      d[52]    = avl;
      d[54]    = db;
      d[55]    = g;
      d[63:56] = base[31:24];
      return d;
   endfunction

   // Behavioural reference: {fault, linear}
   function automatic logic [33:0] model(input logic [63:0] d, input logic [1:0] acc,
                                         input logic [31:0] off);
      longint unsigned base = {d[63:56], d[39:16]};
      longint unsigned lim  = {d[51:48], d[15:0]};
      longint unsigned eff, top, o;
      bit code, ok_type, ok_lim;
      o    = off;
      eff  = d[55] ? lim * 4096 + 4095 : lim;
      top  = d[54] ? 64'hFFFF_FFFF : 64'hFFFF;
      code = d[43];
      if (!d[47]) return {2'd2, 32'd0};
      if (!d[44]) ok_type = 0;
      else if (code) ok_type = (acc == 2) || (acc == 0 && d[41]);
      else ok_type = (acc == 0) || (acc == 1 && d[41]);
      if (!code && d[42]) ok_lim = (o > eff) && (o <= top);
      else ok_lim = (o <= eff);
      if (!ok_type || !ok_lim) return {2'd1, 32'd0};
      return {2'd0, 32'(base + o)};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input bit v, input logic [63:0] d, input logic [1:0] a,
                       input logic [31:0] o, input bit rr, input string tag);
      req_valid = v; req_desc = d; req_acc = a; req_off = o; rsp_ready = rr;
      #1;
      chk("R10 rsp_valid", 32'(rsp_valid), 32'(exp_q.size() != 0));
      chk("R10 req_ready", 32'(req_ready), 32'((exp_q.size() == 0) || rr));
      if (rsp_valid && rsp_ready && exp_q.size() != 0) begin
         logic [33:0] e = exp_q.pop_front();
         string t = tag_q.pop_front();
         chk({t, " fault"}, 32'(rsp_fault), 32'(e[33:32]));
         chk({t, " R11 lin"}, rsp_lin, e[31:0]);
      end
      if (req_valid && req_ready) begin
         exp_q.push_back(model(d, a, o));
         tag_q.push_back(tag);
      end
      @(posedge clk); @(negedge clk);
   endtask

   task automatic go(input logic [63:0] d, input logic [1:0] a, input logic [31:0] o,
                     input string tag);
      step(1'b1, d, a, o, 1'b1, tag);
   endtask

   task automatic idle();
      step(1'b0, '0, '0, '0, 1'b1, "");
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      logic [63:0] dsc;
      repeat (3) @(negedge clk);
      chk("R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
      chk("R1 req_ready in reset", 32'(req_ready), 32'd1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);

      // R2 field placement, ignored bits, wrap
      go(mk(32'h1234_5678, 20'hFFFFF, 4'h2, 1, 1, 1, 1, 2'd0, 0), 0, 32'h10, "R2 base");
      go(mk(32'h1234_5678, 20'hFFFFF, 4'h2, 1, 1, 1, 1, 2'd3, 1), 0, 32'h10, "R2 ignored bits");
      dsc = mk(32'hA1B2_C3D4, 20'hFFFFF, 4'h3, 1, 1, 1, 1, 2'd0, 0);
      dsc[53] = 1'b1;
      go(dsc, 1, 32'h0101_0101, "R2 reserved bit");
      go(mk(32'hFFFF_FFF0, 20'hFFFFF, 4'h2, 1, 1, 1, 1, 2'd0, 0), 1, 32'h20, "R2 wrap");
      // R3 / R4 granularity and upper edge
      go(mk(32'h1000, 20'h00FFF, 4'h2, 1, 1, 1, 0, 2'd0, 0), 0, 32'hFFF, "R4 at limit");
      go(mk(32'h1000, 20'h00FFF, 4'h2, 1, 1, 1, 0, 2'd0, 0), 0, 32'h1000, "R4 past limit");
      go(mk(32'h1000, 20'h00001, 4'h2, 1, 1, 1, 1, 2'd0, 0), 0, 32'h1FFF, "R3 page top");
      go(mk(32'h1000, 20'h00001, 4'h2, 1, 1, 1, 1, 2'd0, 0), 0, 32'h2000, "R3 page past");
      go(mk(32'h1000, 20'hFFFFF, 4'hA, 1, 1, 1, 0, 2'd0, 0), 2, 32'h10_0000, "R4 code byte gran");
      // R5 expand-down
      go(mk(32'h0, 20'h00FFF, 4'h6, 1, 1, 0, 0, 2'd0, 0), 0, 32'hFFF, "R5 at limit");
      go(mk(32'h0, 20'h00FFF, 4'h6, 1, 1, 0, 0, 2'd0, 0), 1, 32'h1000, "R5 above limit");
      go(mk(32'h0, 20'h00FFF, 4'h6, 1, 1, 0, 0, 2'd0, 0), 0, 32'hFFFF, "R5 narrow top");
      go(mk(32'h0, 20'h00FFF, 4'h6, 1, 1, 0, 0, 2'd0, 0), 0, 32'h10000, "R5 narrow over");
      go(mk(32'h0, 20'h00FFF, 4'h6, 1, 1, 1, 0, 2'd0, 0), 0, 32'h10000, "R5 wide");
      go(mk(32'h5, 20'h00FFF, 4'h4, 1, 1, 1, 0, 2'd0, 0), 0, 32'hFFFF_FFFF, "R5 wide top");
      // R6 / R9 priority
      go(mk(32'h0, 20'h0, 4'h0, 0, 0, 0, 0, 2'd0, 0), 2, 32'hFFFF, "R6 absent system");
      go(mk(32'h0, 20'hFFFFF, 4'h2, 1, 0, 1, 1, 2'd0, 0), 0, 32'h0, "R6 absent valid");
      go(mk(32'h0, 20'h0, 4'h8, 1, 0, 0, 0, 2'd0, 0), 1, 32'h9999, "R9 absent over type");
      go(mk(32'h0, 20'h0, 4'h0, 1, 1, 0, 0, 2'd0, 0), 1, 32'h9999, "R9 type and limit");
      // R7 code rules
      go(mk(32'h100, 20'hFFFF, 4'hA, 1, 1, 0, 0, 2'd0, 0), 0, 32'h4, "R7 read readable");
      go(mk(32'h100, 20'hFFFF, 4'hA, 1, 1, 0, 0, 2'd0, 0), 1, 32'h4, "R7 write code");
      go(mk(32'h100, 20'hFFFF, 4'h8, 1, 1, 0, 0, 2'd0, 0), 0, 32'h4, "R7 read exec-only");
      go(mk(32'h100, 20'hFFFF, 4'h8, 1, 1, 0, 0, 2'd0, 0), 2, 32'h4, "R7 exec");
      // R8 data and system rules
      go(mk(32'h200, 20'hFFFF, 4'h0, 1, 1, 0, 0, 2'd0, 0), 1, 32'h4, "R8 write read-only");
      go(mk(32'h200, 20'hFFFF, 4'h1, 1, 1, 0, 0, 2'd0, 0), 0, 32'h4, "R8 read read-only");
      go(mk(32'h200, 20'hFFFF, 4'h2, 1, 1, 0, 0, 2'd0, 0), 2, 32'h4, "R8 exec data");
      go(mk(32'h200, 20'hFFFF, 4'h2, 0, 1, 0, 0, 2'd0, 0), 0, 32'h4, "R8 system");
      go(mk(32'h200, 20'hFFFF, 4'h2, 1, 1, 0, 0, 2'd0, 0), 3, 32'h4, "R8 rsvd access");
      idle(); idle();
      // R10 stall with back-to-back request held
      step(1, mk(32'h300, 20'hFFFF, 4'h2, 1, 1, 0, 0, 2'd0, 0), 0, 32'h7, 1, "R10 stall first");
      step(1, mk(32'h400, 20'hFFFF, 4'h2, 1, 1, 0, 0, 2'd0, 0), 0, 32'h8, 0, "R10 stall second");
      step(1, mk(32'h400, 20'hFFFF, 4'h2, 1, 1, 0, 0, 2'd0, 0), 0, 32'h8, 0, "R10 stall second");
      step(1, mk(32'h400, 20'hFFFF, 4'h2, 1, 1, 0, 0, 2'd0, 0), 0, 32'h8, 1, "R10 stall second");
      idle(); idle();
      // Mixed traffic around edges, random backpressure
      for (int i = 0; i < 4000; i++) begin
         logic [19:0] l = 20'($urandom);
         logic [31:0] o;
         logic [63:0] d = mk($urandom, l, 4'($urandom), ($urandom % 8) != 0,
                             ($urandom % 8) != 0, 1'($urandom), 1'($urandom),
                             2'($urandom), 1'($urandom));
         case ($urandom % 4)
            0: o = d[55] ? {l, 12'hFFF} : {12'h0, l};
            1: o = (d[55] ? {l, 12'hFFF} : {12'h0, l}) + 1;
            2: o = d[54] ? 32'hFFFF_FFFF : 32'hFFFF + ($urandom % 2);
            default: o = $urandom;
         endcase
         step(($urandom % 4) != 0, d, 2'($urandom), o, ($urandom % 3) != 0, "R2-mix");
      end
      while (exp_q.size() != 0) idle();
      idle();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule